// File: doc/BRIEF.md
# UART Interrupt Enable and Identification

This block is the interrupt controller of one UART channel. It holds an 8-bit enable register and watches level and pulse signals from the receive path, the transmit path, the line status logic, the modem delta bits, the software flow control detector and the CTS and RTS pins. Each source that is pending and enabled requests an interrupt. The block drives one interrupt output and a 4-bit identification code. The code names the single highest-priority request. The host reads this code to find the cause of the interrupt.

With every enable bit at zero, the channel runs polled: the interrupt output stays low and the code reads "nothing pending". The host then reads the status registers directly. Those registers sit outside this block. Two sources hold their own pending state. The first is the transmit-empty event, which is cleared by an identification read or by a write to the transmit holding register. The second is the flow-pin rising-edge event, which is cleared by an identification read. All other sources follow their inputs level for level. For the receive source, the comparison used depends on whether FIFO mode is selected.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The enable register is 8 bits wide and resets to 0. It loads `en_wdata` on a cycle where `en_wr` is high, and `en_q` shows its value from the next cycle. The bit meanings are: bit0 receive ready, bit1 transmit empty, bit2 line status, bit3 modem status, bit4 sleep, bit5 Xoff seen, bit6 RTS rise, bit7 CTS rise.
- R2: While `en_q` is 0, `irq` is 0 and `irq_id` is 4'h1, whatever the source inputs are.
- R3: `irq` is high exactly when at least one enabled source is pending. `irq_id` bit0 is 1 exactly when none is pending.
- R4: When `fifo_mode` is 1, the receive source is pending while `rx_count >= rx_trig` and clears as soon as the count falls below `rx_trig`. Its code is 4'h4.
- R5: When `fifo_mode` is 0, the receive source follows `rhr_full`, and `rx_count` has no effect.
- R6: The transmit source becomes pending on the cycle after `tx_empty` rises from 0 to 1, and its code is 4'h2. It is cleared by a `thr_wr` pulse. It is also cleared by an `iir_rd` pulse, but only if 4'h2 is the code reported during that pulse; reading any other code leaves it pending.
- R7: The line status source is pending while any bit of `lsr_err[3:0]` is 1. Its code is 4'h6.
- R8: The modem source is pending while any bit of `msr_delta[3:0]` is 1. Its code is 4'h0.
- R9: A 0-to-1 change of `cts_in` with bit7 set, or of `rts_in` with bit6 set, latches a flow event with code 4'hA. The event is visible from the next cycle. It is cleared by `iir_rd` while 4'hA is reported. A pin that stays high does not raise it again.
- R10: Priority runs from highest to lowest: line status, receive, transmit, modem, Xoff, flow pins. `irq_id` reports only the highest enabled pending source.
- R11: Bit4 (sleep) never raises `irq`, whatever the source inputs are.
- R12: The Xoff source follows the `xoff_hit` level when bit5 is set. Its code is 4'h8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| en_q | output | 8 | Current enable register value |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive trigger level |
| rhr_full | input | 1 | Receive holding register holds data (non-FIFO mode) |
| tx_empty | input | 1 | Transmit FIFO or holding register is empty |
| thr_wr | input | 1 | Pulse: host wrote the transmit holding register |
| lsr_err | input | 4 | Receive error and break status bits |
| msr_delta | input | 4 | Modem status change bits |
| xoff_hit | input | 1 | Xoff character received (level) |
| cts_in | input | 1 | CTS pin level, synchronous |
| rts_in | input | 1 | RTS pin level, synchronous |
| iir_rd | input | 1 | Pulse: host reads the identification code |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Identification code (4'h1 = none pending) |

## Verification
The bench builds the block with FIFO_DEPTH = 16, which makes CNT_W = 5. With this size the trigger boundary can be stepped one count at a time: just below the trigger, at it, above it, and back below it. A large `rx_count` can also be driven in non-FIFO mode to show that it is ignored there. Sources are stacked one at a time and then peeled away one by one, so every step of the priority order is checked. The clear rules are tested against identification reads that report some other source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MS   = 4'h0,
    ID_NONE = 4'h1,
    ID_TX   = 4'h2,
    ID_RX   = 4'h4,
    ID_LS   = 4'h6,
    ID_XOFF = 4'h8,
    ID_FLOW = 4'hA
  } irq_id_e;

  // enable register bit positions
  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int EN_LS   = 2;
  localparam int EN_MS   = 3;
  localparam int EN_SLP  = 4;
  localparam int EN_XOFF = 5;
  localparam int EN_RTS  = 6;
  localparam int EN_CTS  = 7;

  // request slots, index 0 = highest priority
  localparam int NSRC   = 6;
  localparam int S_LS   = 0;
  localparam int S_RX   = 1;
  localparam int S_TX   = 2;
  localparam int S_MS   = 3;
  localparam int S_XOFF = 4;
  localparam int S_FLOW = 5;

  function automatic irq_id_e slot_code(input int slot);
    case (slot)
      S_LS:    return ID_LS;
      S_RX:    return ID_RX;
      S_TX:    return ID_TX;
      S_MS:    return ID_MS;
      S_XOFF:  return ID_XOFF;
      S_FLOW:  return ID_FLOW;
      default: return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uirq_edge_latch.sv
// Sticky rising-edge catchers for the flow-control pins.
module uirq_edge_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] arm,
  input  logic         clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pin_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_d[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        pin_d[i] <= pin[i];
        // a new edge wins over a clear aimed at the older event
        pend[i]  <= (pend[i] & ~clr) | (pin[i] & ~pin_d[i] & arm[i]);
      end
    end
  end
endmodule

// File: rtl/uirq_tx_latch.sv
// Transmit-empty event: set on the empty flag rising, cleared by write or read.
module uirq_tx_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic thr_wr,
  input  logic rd_clr,
  output logic pend
);
  logic empty_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_d <= 1'b1;
      pend    <= 1'b0;
    end else begin
      empty_d <= tx_empty;
      if (thr_wr || rd_clr)
        pend <= 1'b0;
      else if (tx_empty && !empty_d)
        pend <= 1'b1;
    end
  end
endmodule

// File: rtl/uirq_prio_enc.sv
// Fixed-priority pick of the reported source; slot 0 ranks highest.
module uirq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output irq_id_e      id
);
  always_comb begin
    id = ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = slot_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 32,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  output logic [7:0]       en_q,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rhr_full,
  input  logic             tx_empty,
  input  logic             thr_wr,
  input  logic [3:0]       lsr_err,
  input  logic [3:0]       msr_delta,
  input  logic             xoff_hit,
  input  logic             cts_in,
  input  logic             rts_in,
  input  logic             iir_rd,
  output logic             irq,
  output logic [3:0]       irq_id
);
  localparam int NFLOW = 2;  // slot 0 CTS, slot 1 RTS

  logic [NSRC-1:0]  req;
  logic [NFLOW-1:0] flow_pend;
  logic [NFLOW-1:0] flow_arm;
  logic             tx_pend;
  logic             rx_lvl;
  irq_id_e          id_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_wr)  en_q <= en_wdata;
  end

  assign rx_lvl   = fifo_mode ? (rx_count >= rx_trig) : rhr_full;
  assign flow_arm = {en_q[EN_RTS], en_q[EN_CTS]};

  uirq_tx_latch u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_empty (tx_empty),
    .thr_wr   (thr_wr),
    .rd_clr   (iir_rd && (id_sel == ID_TX)),
    .pend     (tx_pend)
  );

  uirq_edge_latch #(.N(NFLOW)) u_flow (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({rts_in, cts_in}),
    .arm   (flow_arm),
    .clr   (iir_rd && (id_sel == ID_FLOW)),
    .pend  (flow_pend)
  );

  always_comb begin
    req         = '0;
    req[S_LS]   = en_q[EN_LS]   & (|lsr_err);
    req[S_RX]   = en_q[EN_RX]   & rx_lvl;
    req[S_TX]   = en_q[EN_TX]   & tx_pend;
    req[S_MS]   = en_q[EN_MS]   & (|msr_delta);
    req[S_XOFF] = en_q[EN_XOFF] & xoff_hit;
    req[S_FLOW] = |(flow_pend & flow_arm);
  end

  uirq_prio_enc #(.N(NSRC)) u_enc (
    .req (req),
    .id  (id_sel)
  );

  assign irq    = |req;
  assign irq_id = id_sel;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr,
  input logic [7:0]       en_wdata,
  input logic [7:0]       en_q,
  input logic             fifo_mode,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rx_trig,
  input logic             rhr_full,
  input logic             tx_empty,
  input logic             thr_wr,
  input logic [3:0]       lsr_err,
  input logic [3:0]       msr_delta,
  input logic             xoff_hit,
  input logic             cts_in,
  input logic             rts_in,
  input logic             iir_rd,
  input logic             irq,
  input logic [3:0]       irq_id
);
  a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_q == $past(en_wdata));

  a_r2_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 8'h00) |-> (!irq && irq_id == ID_NONE));

  a_r3_irq_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !irq_id[0]);

  a_r4_fifo_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && en_q[EN_RX] && rx_count >= rx_trig) |-> irq);

  a_r6_write_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> irq_id != ID_TX);

  a_r7_ls_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[EN_LS] && lsr_err != 4'h0) |-> irq_id == ID_LS);

  a_r9_cts_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cts_in) && en_q[EN_CTS]) |=> irq);

  a_r11_sleep_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 8'h10) |-> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_wr = 1'b0;
  logic [7:0]    en_wdata = '0;
  logic [7:0]    en_q;
  logic          fifo_mode = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [CW-1:0] rx_trig = CW'(4);
  logic          rhr_full = 1'b0;
  logic          tx_empty = 1'b1;
  logic          thr_wr = 1'b0;
  logic [3:0]    lsr_err = '0;
  logic [3:0]    msr_delta = '0;
  logic          xoff_hit = 1'b0;
  logic          cts_in = 1'b0;
  logic          rts_in = 1'b0;
  logic          iir_rd = 1'b0;
  logic          irq;
  logic [3:0]    irq_id;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       irq;
    logic [3:0] id;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(DEPTH)) u_uart_irq_ctrl (.*);

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (irq !== e.irq || irq_id !== e.id) begin
          errors++;
          $display("FAIL %s: irq=%0b id=%h expected irq=%0b id=%h",
                   e.tag, irq, irq_id, e.irq, e.id);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(input logic ei, input logic [3:0] eid, input string tag);
    exp_t e;
    e.irq = ei; e.id = eid; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    #2;
  endtask

  task automatic set_en(input logic [7:0] v);
    en_wdata = v; en_wr = 1'b1; tick(); en_wr = 1'b0;
  endtask

  task automatic read_id();
    iir_rd = 1'b1; tick(); iir_rd = 1'b0;
  endtask

  task automatic write_thr();
    thr_wr = 1'b1; tick(); thr_wr = 1'b0;
  endtask

  task automatic tx_cycle();  // empty flag drops then rises again
    tx_empty = 1'b0; tick(); tx_empty = 1'b1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R1 reset state
    checks++;
    if (en_q !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset enable: got %h expected 00", en_q);
    end
    expect_out(1'b0, 4'h1, "R1 reset outputs");

    // R2 polled mode: all sources active, nothing enabled
    lsr_err = 4'h3; msr_delta = 4'h1; xoff_hit = 1'b1; rhr_full = 1'b1;
    fifo_mode = 1'b1; rx_count = CW'(9);
    tx_cycle();
    cts_in = 1'b1; tick();
    expect_out(1'b0, 4'h1, "R2 polled");
    lsr_err = '0; msr_delta = '0; xoff_hit = 1'b0; rhr_full = 1'b0;
    rx_count = '0; cts_in = 1'b0;
    write_thr();  // drop any transmit event so later steps start clean

    // R1 enable write read back, R4 trigger both ways
    set_en(8'h01);
    checks++;
    if (en_q !== 8'h01) begin
      errors++;
      $display("FAIL R1 enable write: got %h expected 01", en_q);
    end
    rx_count = CW'(3); expect_out(1'b0, 4'h1, "R4 below trigger");
    rx_count = CW'(4); expect_out(1'b1, 4'h4, "R4 at trigger");
    rx_count = CW'(5); expect_out(1'b1, 4'h4, "R4 above trigger");
    rx_count = CW'(3); expect_out(1'b0, 4'h1, "R4 drops below");

    // R5 non-FIFO mode
    fifo_mode = 1'b0; rx_count = CW'(10);
    expect_out(1'b0, 4'h1, "R5 count ignored");
    rhr_full = 1'b1; expect_out(1'b1, 4'h4, "R5 holding full");
    rhr_full = 1'b0; rx_count = '0; expect_out(1'b0, 4'h1, "R5 holding empty");

    // R6 transmit empty, cleared by read and by write
    set_en(8'h02);
    tx_cycle(); expect_out(1'b1, 4'h2, "R6 empty rises");
    read_id();  expect_out(1'b0, 4'h1, "R6 read clears");
    tx_cycle(); expect_out(1'b1, 4'h2, "R6 empty again");
    write_thr(); expect_out(1'b0, 4'h1, "R6 write clears");

    // R6 read reporting another source keeps transmit pending
    set_en(8'h06);
    tx_cycle(); lsr_err = 4'h4;
    expect_out(1'b1, 4'h6, "R7 line status over tx");
    read_id(); lsr_err = 4'h0;
    expect_out(1'b1, 4'h2, "R6 survives other read");
    write_thr();

    // R7, R8
    set_en(8'h04); lsr_err = 4'h8; expect_out(1'b1, 4'h6, "R7 line status");
    lsr_err = 4'h0; expect_out(1'b0, 4'h1, "R7 cleared");
    set_en(8'h08); msr_delta = 4'h2; expect_out(1'b1, 4'h0, "R8 modem");
    msr_delta = 4'h0; expect_out(1'b0, 4'h1, "R8 cleared");

    // R10 priority ladder
    set_en(8'hFF);
    fifo_mode = 1'b1; rx_count = CW'(4); lsr_err = 4'h1; msr_delta = 4'h4;
    xoff_hit = 1'b1; tx_cycle();
    expect_out(1'b1, 4'h6, "R10 line status first");
    lsr_err = '0;   expect_out(1'b1, 4'h4, "R10 receive second");
    rx_count = '0;  expect_out(1'b1, 4'h2, "R10 transmit third");
    read_id();      expect_out(1'b1, 4'h0, "R10 modem fourth");
    msr_delta = '0; expect_out(1'b1, 4'h8, "R10 xoff fifth");
    cts_in = 1'b1; tick();
    expect_out(1'b1, 4'h8, "R10 xoff over flow");
    xoff_hit = 1'b0; expect_out(1'b1, 4'hA, "R10 flow last");
    read_id(); cts_in = 1'b0; expect_out(1'b0, 4'h1, "R9 flow read clears");

    // R11 sleep bit alone
    set_en(8'h10);
    lsr_err = 4'hF; msr_delta = 4'hF; xoff_hit = 1'b1; rx_count = CW'(8);
    tx_cycle();
    expect_out(1'b0, 4'h1, "R11 sleep silent");
    lsr_err = '0; msr_delta = '0; xoff_hit = 1'b0; rx_count = '0;
    write_thr();

    // R12 Xoff
    set_en(8'h20); xoff_hit = 1'b1; expect_out(1'b1, 4'h8, "R12 xoff");
    xoff_hit = 1'b0; expect_out(1'b0, 4'h1, "R12 xoff gone");

    // R9 CTS and RTS edges
    set_en(8'h80);
    cts_in = 1'b1; tick(); expect_out(1'b1, 4'hA, "R9 cts rise");
    read_id();     expect_out(1'b0, 4'h1, "R9 cts cleared");
    tick();        expect_out(1'b0, 4'h1, "R9 cts held high no refire");
    cts_in = 1'b0; tick(); cts_in = 1'b1; tick();
    expect_out(1'b1, 4'hA, "R9 cts second rise");
    read_id();
    rts_in = 1'b1; tick(); expect_out(1'b0, 4'h1, "R9 rts not enabled");
    rts_in = 1'b0; tick();
    set_en(8'h40);
    rts_in = 1'b1; tick(); expect_out(1'b1, 4'hA, "R9 rts rise");
    read_id();     expect_out(1'b0, 4'h1, "R9 rts cleared");

    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule